// File: doc/BRIEF.md
# State-Switching Branch Exchange Sequencer

This block drives the instruction bus during an indirect branch that takes both its target and its new instruction-set state from a register. The core runs in one of two states: a word state, where each instruction is 32 bits wide, and a halfword state, where each instruction is 16 bits wide. A one-cycle start strobe presents the current program counter, the current state bit and the source register. The block then runs three bus cycles. The first is a prefetch from the old stream that cannot be cancelled. The second fetches from the branch target. The third fetches the next instruction after the target, which refills the pipeline.

Bit 0 of the source register selects the new state: 0 selects the word state and 1 selects the halfword state. The branch target is the register value with bit 0 forced to zero. The step between fetches and the access-size code both follow the state bit. The state bit switches between the first and second cycles, so the width changes partway through the sequence.

Top module: `xchg_branch_seq`

## Requirements
- R1: After `start` is sampled high while the block is idle, `memReqN` is low for exactly three consecutive cycles, and then the block returns to idle.
- R2: In the first cycle, `busAddr` equals the captured PC plus 8 when the old state bit is 0, and plus 4 when it is 1. In that cycle `seqCycle` is 0, and `stateBit` shows the old state sampled from `curState` at start.
- R3: In every active cycle, `accessSize` is 2 when `stateBit` is 0 and 1 when `stateBit` is 1.
- R4: In the second cycle, `busAddr` equals `srcReg` with bit 0 cleared, `seqCycle` is 1, and `stateBit` equals bit 0 of `srcReg`.
- R5: In the third cycle, `busAddr` equals the target plus 4 for new state 0, and plus 2 for new state 1. In that cycle `seqCycle` is 1 and `stateBit` is unchanged from the second cycle.
- R6: In all three active cycles, `busWrite` is 0 and `opFetchN` is 0. When idle, `memReqN` is 1, `opFetchN` is 1 and `seqCycle` is 0.
- R7: A `start` pulse during an active sequence is ignored, so the running sequence's addresses and state are unchanged. `stateBit` holds its value while the block is idle.
- R8: After reset, the block is idle and `stateBit` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a sequence |
| curPc | input | ADDR_W | Address of the branch instruction |
| curState | input | 1 | State bit before the branch |
| srcReg | input | ADDR_W | Source register: target address, and new state in bit 0 |
| busAddr | output | ADDR_W | Fetch address |
| accessSize | output | 2 | Access-size code (2 = word, 1 = halfword) |
| busWrite | output | 1 | 1 = write; always 0 here |
| memReqN | output | 1 | Active-low memory request |
| seqCycle | output | 1 | Sequential-access indicator |
| opFetchN | output | 1 | Active-low opcode-fetch indicator |
| stateBit | output | 1 | Current instruction-set state |

## Verification
The hardest case to reach is a state change in the middle of the sequence that also hits the edges of the address space. The step and size code must switch exactly between the first and second cycles, including when the prefetch address or the refill address wraps past the top of the address space. The bench sweeps all four pairs of old and new state against several PC and target values, including ones next to the wrap point and targets with bit 0 set. A second start pulse is injected in the middle of a sequence with conflicting operands, to show it has no effect.

// File: rtl/bxs_pkg.sv
package bxs_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_PREF, PH_TGT, PH_FILL} phase_e;

  typedef struct packed {
    logic capture;
    logic prefetch;
    logic target;
    logic refill;
    logic commit;
  } strobe_t;

  localparam logic [1:0] SIZE_HALF = 2'd1;
  localparam logic [1:0] SIZE_WORD = 2'd2;
endpackage

// File: rtl/bxs_ctrl.sv
module bxs_ctrl
  import bxs_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  output strobe_t strobes
);
  phase_e phase, phaseNext;

  always_comb begin
    phaseNext = phase;
    unique case (phase)
      PH_IDLE: if (start) phaseNext = PH_PREF;
      PH_PREF: phaseNext = PH_TGT;
      PH_TGT:  phaseNext = PH_FILL;
      PH_FILL: phaseNext = PH_IDLE;
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= phaseNext;
  end

  always_comb begin
    strobes.capture  = (phase == PH_IDLE) && start;
    strobes.prefetch = (phase == PH_PREF);
    strobes.target   = (phase == PH_TGT);
    strobes.refill   = (phase == PH_FILL);
    strobes.commit   = (phase == PH_PREF);
  end

  assert_pref_to_tgt_R1: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.prefetch |=> strobes.target);
  assert_tgt_to_fill_R1: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.target |=> strobes.refill);
  assert_fill_to_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.refill |=> !(strobes.prefetch || strobes.target || strobes.refill));
  assert_one_phase_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobes.prefetch, strobes.target, strobes.refill}));
endmodule

// File: rtl/bxs_datapath.sv
module bxs_datapath
  import bxs_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           strobes,
  input  logic [ADDR_W-1:0] curPc,
  input  logic              curState,
  input  logic [ADDR_W-1:0] srcReg,
  output logic [ADDR_W-1:0] busAddr,
  output logic [1:0]        accessSize,
  output logic              busWrite,
  output logic              memReqN,
  output logic              seqCycle,
  output logic              opFetchN,
  output logic              stateBit
);
  localparam logic [ADDR_W-1:0] STEP_WORD = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] STEP_HALF = ADDR_W'(2);

  logic [ADDR_W-1:0] pcReg, tgtReg, stepNow;
  logic              newBit, stateReg, active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcReg    <= '0;
      tgtReg   <= '0;
      newBit   <= 1'b0;
      stateReg <= 1'b0;
    end else if (strobes.capture) begin
      pcReg    <= curPc;
      tgtReg   <= {srcReg[ADDR_W-1:1], 1'b0};
      newBit   <= srcReg[0];
      stateReg <= curState;
    end else if (strobes.commit) begin
      stateReg <= newBit;
    end
  end

  assign stepNow = stateReg ? STEP_HALF : STEP_WORD;
  assign active  = strobes.prefetch | strobes.target | strobes.refill;

  always_comb begin
    busAddr = '0;
    if (strobes.prefetch)    busAddr = pcReg + (stepNow << 1);
    else if (strobes.target) busAddr = tgtReg;
    else if (strobes.refill) busAddr = tgtReg + stepNow;
  end

  assign accessSize = stateReg ? SIZE_HALF : SIZE_WORD;
  assign busWrite   = 1'b0;
  assign memReqN    = ~active;
  assign opFetchN   = ~active;
  assign seqCycle   = strobes.target | strobes.refill;
  assign stateBit   = stateReg;

  assert_refill_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.refill |-> (busAddr - $past(busAddr)) == (stateBit ? STEP_HALF : STEP_WORD));
  assert_state_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.refill |-> $stable(stateBit));
  assert_target_even_R4: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.target |-> busAddr[0] == 1'b0);
  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (memReqN && $past(memReqN) && !$past(strobes.capture)) |-> $stable(stateBit));
  assert_read_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !memReqN |-> (!busWrite && !opFetchN));
  assert_size_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !memReqN |-> accessSize == (stateBit ? 2'd1 : 2'd2));
endmodule

// File: rtl/xchg_branch_seq.sv
module xchg_branch_seq
  import bxs_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] curPc,
  input  logic              curState,
  input  logic [ADDR_W-1:0] srcReg,
  output logic [ADDR_W-1:0] busAddr,
  output logic [1:0]        accessSize,
  output logic              busWrite,
  output logic              memReqN,
  output logic              seqCycle,
  output logic              opFetchN,
  output logic              stateBit
);
  strobe_t strobes;

  bxs_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .strobes (strobes)
  );

  bxs_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobes    (strobes),
    .curPc      (curPc),
    .curState   (curState),
    .srcReg     (srcReg),
    .busAddr    (busAddr),
    .accessSize (accessSize),
    .busWrite   (busWrite),
    .memReqN    (memReqN),
    .seqCycle   (seqCycle),
    .opFetchN   (opFetchN),
    .stateBit   (stateBit)
  );
endmodule

// File: tb/xchg_branch_seq_tb.sv
module xchg_branch_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [ADDR_W-1:0] curPc = '0;
  logic curState = 1'b0;
  logic [ADDR_W-1:0] srcReg = '0;
  logic [ADDR_W-1:0] busAddr;
  logic [1:0] accessSize;
  logic busWrite, memReqN, seqCycle, opFetchN, stateBit;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xchg_branch_seq #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .curPc(curPc), .curState(curState),
    .srcReg(srcReg), .busAddr(busAddr), .accessSize(accessSize), .busWrite(busWrite),
    .memReqN(memReqN), .seqCycle(seqCycle), .opFetchN(opFetchN), .stateBit(stateBit)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chkIdle(input string req);
    chk(memReqN == 1'b1, req, memReqN, 1);
    chk(opFetchN == 1'b1, req, opFetchN, 1);
    chk(seqCycle == 1'b0, req, seqCycle, 0);
  endtask

  task automatic chkActive(input logic [ADDR_W-1:0] expAddr, input bit expSeq, input bit expState);
    chk(memReqN == 1'b0, "R1", memReqN, 0);
    chk(busWrite == 1'b0 && opFetchN == 1'b0, "R6", {busWrite, opFetchN}, 0);
    chk(busAddr == expAddr, "R2/R4/R5 addr", busAddr, expAddr);
    chk(seqCycle == expSeq, "R2/R4/R5 seq", seqCycle, expSeq);
    chk(stateBit == expState, "R2/R4/R5 state", stateBit, expState);
    chk(accessSize == (expState ? 2'd1 : 2'd2), "R3", accessSize, expState ? 1 : 2);
  endtask

  // Runs one sequence. When intrude is set, a conflicting start pulse arrives in cycle 1.
  task automatic runSeq(input logic [ADDR_W-1:0] pc, input logic [ADDR_W-1:0] src,
                        input bit oldS, input bit intrude);
    logic [ADDR_W-1:0] tgt;
    logic [ADDR_W-1:0] oldW, newW;
    bit newS;
    tgt  = {src[ADDR_W-1:1], 1'b0};
    newS = src[0];
    oldW = oldS ? 2 : 4;
    newW = newS ? 2 : 4;
    curPc = pc; srcReg = src; curState = oldS; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // cycle 1: R2
    chkActive(pc + 2*oldW, 1'b0, oldS);
    if (intrude) begin
      start = 1'b1; curPc = ~pc; srcReg = ~src; curState = ~oldS;
    end
    @(negedge clk);
    start = 1'b0;
    // cycle 2: R4; R7 when intruded
    chkActive(tgt, 1'b1, newS);
    @(negedge clk);
    // cycle 3: R5
    chkActive(tgt + newW, 1'b1, newS);
    @(negedge clk);
    chkIdle("R1 idle after three");
    @(negedge clk);
    chkIdle("R6 idle");
    chk(stateBit == newS, "R7 hold", stateBit, newS);
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [ADDR_W-1:0] pcs [4];
    logic [ADDR_W-1:0] tgts [4];
    pcs[0] = 32'h0000_0000; pcs[1] = 32'h0000_1234;
    pcs[2] = 32'hFFFF_FFFC; pcs[3] = 32'h8000_0002;
    tgts[0] = 32'h0000_0100; tgts[1] = 32'hFFFF_FFFE;
    tgts[2] = 32'h4000_0AB0; tgts[3] = 32'hFFFF_FFFC;
    repeat (2) @(negedge clk);
    // R8 reset state
    chkIdle("R8");
    chk(stateBit == 1'b0, "R8 state", stateBit, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chkIdle("R8 after release");
    for (int p = 0; p < 4; p++)
      for (int t = 0; t < 4; t++)
        for (int o = 0; o < 2; o++)
          for (int n = 0; n < 2; n++)
            runSeq(pcs[p], tgts[t] | ADDR_W'(n), o[0], 1'b0);
    // R7: start ignored while busy
    runSeq(32'h0000_2000, 32'h0000_3001, 1'b0, 1'b1);
    runSeq(32'h0000_5002, 32'h0000_6000, 1'b1, 1'b1);
    // R7: idle hold over several cycles
    repeat (5) @(negedge clk);
    chk(stateBit == 1'b0, "R7 idle hold", stateBit, 0);
    chkIdle("R6 long idle");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule